// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block gives a processor the bit-level hardware it needs to act as a slave on a two-wire serial bus (clock line and data line, both open-drain), while the processor keeps every protocol decision. An 8-bit shift register moves data between the data line and a register port. A 4-bit edge counter counts both edges of the bus clock and frames transfers. Bus start and stop conditions are detected and latched as sticky flags. A start or a counter wrap raises an interrupt request and stretches the bus clock low, which gives the processor time to react.

The block does not decode addresses and does not acknowledge on its own. To acknowledge, software clears the shift register, enables the data drive and preloads the counter with 14 so that it wraps after exactly two more clock edges. To receive a byte it clears the counter, which then wraps after sixteen edges. Both bus inputs pass through two-flop synchronizers, and all edges and conditions are derived in the system clock domain.

Top module: `tws_top`

## Requirements
- R1: After reset, data (address 0), counter (address 1) and status (address 2) read 0, control (address 3) reads 0x02, and `sda_drive_low`, `scl_drive_low` and `irq` are all 0.
- R2: A falling data line while the clock line is high sets status bit 0 (start) and raises `irq`. Data changes made while the clock is low never set it.
- R3: The counter (address 1, bits 3:0) increments on every synchronized clock edge, rising and falling. This includes the falling edge just after a start.
- R4: When the counter steps from 15 to 0, status bit 1 (overflow) is set and `irq` is raised.
- R5: A register write to address 1 loads the counter, and has priority over an edge in the same cycle. Writing 14 produces an overflow after exactly two further clock edges.
- R6: The line level is sampled on each rising clock edge. On each falling edge the register shifts left and takes in that sample at bit 0. After eight bit periods from a cleared counter, the data register holds the received byte, MSB first.
- R7: `sda_drive_low` is 1 exactly when control bit 0 (drive enable) is 1 and the AND of control bit 1 (latch, reset 1) with data bit 7 is 0. The pad is never driven high.
- R8: If start or overflow is set at a falling clock edge, `scl_drive_low` asserts and stays asserted until both flags are cleared. Status bit 3 mirrors it.
- R9: A rising data line while the clock is high sets status bit 2 (stop). This raises neither `irq` nor a clock hold.
- R10: Writing to status clears each flag whose bit is 1 in the written value. Flags whose bit is 0 are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 data, 1 counter, 2 status, 3 control |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| scl_in | input | 1 | Clock line level from the pad |
| sda_in | input | 1 | Data line level from the pad |
| scl_drive_low | output | 1 | Pull the clock line low (hold) |
| sda_drive_low | output | 1 | Pull the data line low |
| irq | output | 1 | Interrupt request: start or overflow pending |

## Verification
The bench sends an odd byte (0xA5) with data changes only while the clock is low. A detector that looks at data edges without qualifying the clock would report a false start there. The bench checks that the counter already reads 1 after the falling edge that follows a start; a design that ignores that edge delivers every later bit one edge out of phase. The acknowledge slot is framed with a preload of 14 and checked for overflow on the second edge and not the first. The latch-AND-MSB drive rule is checked with the latch at 0: a design that ignored the latch would release the line there instead of pulling it low. Partial write-one-to-clear is checked to leave the other flags untouched.

// File: rtl/tws_pkg.sv
package tws_pkg;

    parameter int DATA_W = 8;
    parameter int CNT_W  = 4;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CNT  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    // status register, bit 0 in the lowest field
    typedef struct packed {
        logic hold;
        logic stop;
        logic ovf;
        logic start;
    } stat_t;

    typedef struct packed {
        logic latch;
        logic oe;
    } ctrl_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // open-drain: pull low unless the AND of latch and MSB releases the line
    function automatic logic pad_pull_low(input logic oe, input logic latch, input logic msb);
        return oe & ~(latch & msb);
    endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int W       = 2,
    parameter int STAGES  = 2,
    parameter logic RST_V = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= {W{RST_V}};
        else     chain[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= {W{RST_V}};
            else     chain[g] <= chain[g-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tws_detect.sv
module tws_detect
    import tws_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
        end
    end

    always_comb begin
        evt.scl_rise = scl & ~scl_p;
        evt.scl_fall = ~scl & scl_p;
        evt.start    = scl & scl_p & sda_p & ~sda;
        evt.stop     = scl & scl_p & ~sda_p & sda;
    end

    // a condition never coincides with a clock edge or with the other condition (R9)
    p_evt_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.scl_rise, evt.scl_fall, evt.start, evt.stop}));
endmodule

// File: rtl/tws_shift.sv
module tws_shift
    import tws_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    input  logic          sda,
    input  logic          data_wr,
    input  logic [DW-1:0] data_wdata,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    output logic [DW-1:0] data_q,
    output logic [CW-1:0] cnt_q,
    output logic          wrap
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic smp_q;
    logic any_edge;

    assign any_edge = evt.scl_rise | evt.scl_fall;
    assign wrap     = any_edge & ~cnt_wr & (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            cnt_q  <= '0;
            smp_q  <= 1'b0;
        end else begin
            if (evt.scl_rise) smp_q <= sda;
            if (data_wr)            data_q <= data_wdata;
            else if (evt.scl_fall)  data_q <= {data_q[DW-2:0], smp_q};
            if (cnt_wr)             cnt_q <= cnt_wdata;
            else if (any_edge)      cnt_q <= cnt_q + 1'b1;
        end
    end

    // every unshadowed clock edge advances the counter by one (R3)
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
        (any_edge && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

    // a counter write takes effect regardless of bus edges (R5)
    p_cnt_load_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_q == $past(cnt_wdata));
endmodule

// File: rtl/tws_top.sv
module tws_top
    import tws_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic       irq
);
    localparam int STAT_W = $bits(stat_t);
    localparam int CTRL_W = $bits(ctrl_t);

    logic [1:0]        line_s;
    bus_evt_t          evt;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wrap;
    stat_t             stat_q;
    ctrl_t             ctrl_q;
    logic              hold_q;
    logic              start_nxt, ovf_nxt, stop_nxt, hold_nxt;
    logic              wr_data, wr_cnt, wr_stat, wr_ctrl;
    reg_sel_e          sel;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_data = reg_wr && (sel == REG_DATA);
    assign wr_cnt  = reg_wr && (sel == REG_CNT);
    assign wr_stat = reg_wr && (sel == REG_STAT);
    assign wr_ctrl = reg_wr && (sel == REG_CTRL);

    tws_sync #(.W(2), .STAGES(2), .RST_V(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_in, sda_in}),
        .dout (line_s)
    );

    tws_detect u_detect (
        .clk (clk),
        .rst (rst),
        .scl (line_s[1]),
        .sda (line_s[0]),
        .evt (evt)
    );

    tws_shift #(.DW(DATA_W), .CW(CNT_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .sda        (line_s[0]),
        .data_wr    (wr_data),
        .data_wdata (reg_wdata[DATA_W-1:0]),
        .cnt_wr     (wr_cnt),
        .cnt_wdata  (reg_wdata[CNT_W-1:0]),
        .data_q     (data_q),
        .cnt_q      (cnt_q),
        .wrap       (wrap)
    );

    // sticky flags: a new event wins over a same-cycle clear
    always_comb begin
        start_nxt = (stat_q.start & ~(wr_stat & reg_wdata[0])) | evt.start;
        ovf_nxt   = (stat_q.ovf   & ~(wr_stat & reg_wdata[1])) | wrap;
        stop_nxt  = (stat_q.stop  & ~(wr_stat & reg_wdata[2])) | evt.stop;
        hold_nxt  = (hold_q | evt.scl_fall) & (start_nxt | ovf_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            hold_q <= 1'b0;
            ctrl_q <= '{latch: 1'b1, oe: 1'b0};
        end else begin
            stat_q.start <= start_nxt;
            stat_q.ovf   <= ovf_nxt;
            stat_q.stop  <= stop_nxt;
            stat_q.hold  <= hold_nxt;
            hold_q       <= hold_nxt;
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        case (sel)
            REG_DATA: reg_rdata = data_q;
            REG_CNT:  reg_rdata = {{(8-CNT_W){1'b0}}, cnt_q};
            REG_STAT: reg_rdata = {{(8-STAT_W){1'b0}}, stat_q};
            default:  reg_rdata = {{(8-CTRL_W){1'b0}}, ctrl_q};
        endcase
    end

    assign sda_drive_low = pad_pull_low(ctrl_q.oe, ctrl_q.latch, data_q[DATA_W-1]);
    assign scl_drive_low = hold_q;
    assign irq           = stat_q.start | stat_q.ovf;

    // a detected start is latched on the following cycle (R2)
    p_start_latch_r2: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> stat_q.start);

    // overflow only appears after the counter stood at its maximum (R4)
    p_ovf_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.ovf) |-> $past(cnt_q) == {CNT_W{1'b1}});

    // the data pad is released whenever the drive is disabled (R7)
    p_sda_release_r7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.oe |-> !sda_drive_low);

    // clock hold only exists while a start or overflow is pending (R8)
    p_hold_flag_r8: assert property (@(posedge clk) disable iff (rst)
        scl_drive_low |-> (stat_q.start || stat_q.ovf));

    // a stop never begins a clock hold (R9)
    p_stop_no_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && !hold_q) |=> !hold_q);
endmodule

// File: tb/tws_top_tb.sv
module tws_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_drive_low, sda_drive_low, irq;
    logic       scl_line, sda_line;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int        kind;   // 0 rdata, 1 sda_drive_low, 2 scl_drive_low, 3 irq
        logic [7:0] exp;
        string     tag;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;

    assign scl_line = scl_m & ~scl_drive_low;
    assign sda_line = sda_m & ~sda_drive_low;

    tws_top u_dut (
        .clk           (clk),
        .rst           (rst),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .irq           (irq)
    );

    // monitor: pops expectations and compares away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {7'd0, sda_drive_low};
                2:       act = {7'd0, scl_drive_low};
                default: act = {7'd0, irq};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_v(input int kind, input logic [1:0] addr, input logic [7:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = addr;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
        while (q.size() != 0) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] addr, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = addr; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    task automatic clk_pulse();
        scl_m = 1'b1; settle();
        scl_m = 1'b0; settle();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; settle();
        clk_pulse();
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        settle();

        // R1 reset state
        expect_v(0, 2'd0, 8'h00, "R1 data");
        expect_v(0, 2'd1, 8'h00, "R1 counter");
        expect_v(0, 2'd2, 8'h00, "R1 status");
        expect_v(0, 2'd3, 8'h02, "R1 control");
        expect_v(1, 2'd0, 8'h00, "R1 sda_drive_low");
        expect_v(3, 2'd0, 8'h00, "R1 irq");

        // R2 start condition
        sda_m = 1'b0; settle();
        expect_v(0, 2'd2, 8'h01, "R2 start flag");
        expect_v(3, 2'd0, 8'h01, "R2 irq on start");
        // R3 falling edge after the start counts; R8 hold follows it
        scl_m = 1'b0; settle();
        expect_v(0, 2'd1, 8'h01, "R3 count after start fall");
        expect_v(2, 2'd0, 8'h01, "R8 hold after start");
        wr(2'd2, 8'h01); settle();
        expect_v(2, 2'd0, 8'h00, "R8 hold released");
        expect_v(3, 2'd0, 8'h00, "R10 irq after clear");

        // R6 receive an odd byte from a cleared counter
        wr(2'd1, 8'h00);
        for (int i = 7; i >= 1; i--) send_bit(1'((8'hA5 >> i) & 1));
        expect_v(0, 2'd1, 8'h0E, "R3 count after seven bits");
        expect_v(0, 2'd2, 8'h00, "R2 no false start on odd data");
        send_bit(1'b1);
        expect_v(0, 2'd1, 8'h00, "R4 counter wrapped");
        expect_v(0, 2'd2, 8'h0A, "R4 overflow and hold");
        expect_v(0, 2'd0, 8'hA5, "R6 received byte");
        expect_v(3, 2'd0, 8'h01, "R4 irq on overflow");
        expect_v(2, 2'd0, 8'h01, "R8 hold after overflow");

        // R5 acknowledge slot framed by a preload of 14
        sda_m = 1'b1;
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h03);
        wr(2'd1, 8'h0E);
        wr(2'd2, 8'h02); settle();
        expect_v(1, 2'd0, 8'h01, "R7 ack drives low");
        scl_m = 1'b1; settle();
        expect_v(0, 2'd2, 8'h00, "R5 no overflow after one edge");
        expect_v(0, 2'd1, 8'h0F, "R5 count after one edge");
        scl_m = 1'b0; settle();
        expect_v(0, 2'd2, 8'h0A, "R5 overflow after two edges");

        // R6 transmit shifting with MSB on the pad
        wr(2'd0, 8'hC0);
        wr(2'd2, 8'h02); settle();
        expect_v(1, 2'd0, 8'h00, "R7 msb one releases");
        clk_pulse();
        expect_v(0, 2'd0, 8'h81, "R6 shift one");
        expect_v(1, 2'd0, 8'h00, "R7 second bit released");
        clk_pulse();
        expect_v(1, 2'd0, 8'h01, "R7 third bit pulls low");

        // R7 latch AND msb
        wr(2'd0, 8'hFF);
        wr(2'd3, 8'h01);
        expect_v(1, 2'd0, 8'h01, "R7 latch zero forces low");
        wr(2'd3, 8'h03);
        expect_v(1, 2'd0, 8'h00, "R7 latch one releases");
        wr(2'd3, 8'h02);
        expect_v(1, 2'd0, 8'h00, "R7 drive disabled");

        // R9 stop condition
        sda_m = 1'b0; settle();
        scl_m = 1'b1; settle();
        sda_m = 1'b1; settle();
        expect_v(0, 2'd2, 8'h04, "R9 stop flag");
        expect_v(3, 2'd0, 8'h00, "R9 no irq on stop");
        expect_v(2, 2'd0, 8'h00, "R9 no hold on stop");

        // R10 partial clear
        sda_m = 1'b0; settle();
        expect_v(0, 2'd2, 8'h05, "R10 start and stop set");
        wr(2'd2, 8'h04);
        expect_v(0, 2'd2, 8'h01, "R10 only stop cleared");
        wr(2'd2, 8'h01);
        expect_v(0, 2'd2, 8'h00, "R10 start cleared");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule